// File: doc/BRIEF.md
# Configuration Capability Chain Decoder

This block sits behind a configuration-space register port that is addressed in dwords. It owns two address windows, a standard window and an extended window. Each window holds a fixed set of capability slots, and each slot has an identifier, a version, a dword offset and a length in dwords, all fixed at elaboration. Every request is steered to the one slot whose span covers the address, together with the dword index relative to that slot's start. The storage behind each slot is outside this block and answers through a plain per-slot read/write port.

The slots form a linked list in ascending offset order. The decoder derives the link pointers itself from the placed offsets. When the first dword of a slot is read, the decoder merges the pointer and the identifier into the returned word. The standard and extended windows use different header layouts. A slot whose offset parameter is zero is given the lowest free position in its window. The decoder also drives the byte address of the first capability in each window, for use by the function's header register.

Top module: `cap_chain_decoder`

## Requirements
- R1: The standard window covers dword addresses 0x010 through 0x03F. The extended window covers 0x040 through 0x3FF. An elaboration-time check rejects any slot that leaves its window, has zero length, or overlaps another slot.
- R2: A request hits slot k when offset_k <= addr < offset_k + length_k. `slot_sel` is one-hot on a hit. Standard slots occupy the low bits of `slot_sel` and extended slots follow. `slot_idx` is addr - offset_k on a hit and zero otherwise.
- R3: A read of dword 0 of a standard slot returns the slot's bits [31:16] unchanged. Bits [15:8] of the result carry the next pointer and bits [7:0] carry the low 8 bits of the slot identifier.
- R4: A read of dword 0 of an extended slot is built entirely by the decoder. Bits [31:20] carry the next pointer, bits [19:16] the version and bits [15:0] the identifier.
- R5: The next pointer of a slot is four times the dword offset of the slot with the next higher offset in the same window. It is zero for the slot with the highest offset.
- R6: `cap_head_ptr` and `ext_head_ptr` are four times the lowest slot offset in their window.
- R7: A read that hits no slot returns zero.
- R8: A write that hits no slot raises neither `slot_wr` nor `slot_rd`, and no slot is selected.
- R9: A slot with offset parameter zero is placed, in slot order after all explicitly placed slots, at the lowest position at or above the window start that overlaps no slot already placed.
- R10: A write that hits forwards `req_wdata` and `req_mask` to the owning slot in the same cycle, with `slot_wr` high.
- R11: `rsp_valid` is high exactly one cycle after a read request and low after writes and idle cycles. A read of any dword other than dword 0 returns the slot's word unchanged.
- R12: During and right after reset, `rsp_valid` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Dword address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Byte enables for the write |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| slot_sel | output | N_STD+N_EXT | One-hot owning slot |
| slot_rd | output | 1 | Read strobe to the selected slot |
| slot_wr | output | 1 | Write strobe to the selected slot |
| slot_idx | output | 10 | Dword index within the slot |
| slot_wdata | output | 32 | Write data to the slot |
| slot_mask | output | 4 | Byte enables to the slot |
| slot_rdata | input | 32*(N_STD+N_EXT) | Per-slot read word at `slot_idx`, combinational |
| cap_head_ptr | output | 8 | Byte address of first standard capability |
| ext_head_ptr | output | 12 | Byte address of first extended capability |

## Verification
The bench builds the decoder with three standard slots and two extended slots. One standard slot is placed explicitly at 0x020. Two standard slots are left at offset zero, so they are placed automatically: the first lands at the window start and the second is pushed past it to 0x016. The placed order therefore differs from the slot index order, which exercises chain sorting. The extended window mixes an automatic slot at 0x040 with a fixed one at 0x100. This gives gaps between slots, last-in-chain headers with a zero pointer, and unmapped addresses just past each slot end and at both window edges.

// File: rtl/cap_chain_pkg.sv
package cap_chain_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int MASK_W = DATA_W / 8;

    localparam logic [ADDR_W-1:0] STD_LO = 10'h010;
    localparam logic [ADDR_W-1:0] STD_HI = 10'h03F;
    localparam logic [ADDR_W-1:0] EXT_LO = 10'h040;
    localparam logic [ADDR_W-1:0] EXT_HI = 10'h3FF;

    localparam int STD_PW = 8;
    localparam int EXT_PW = 12;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rsp_state_t;

endpackage

// File: rtl/cap_region.sv
module cap_region
    import cap_chain_pkg::*;
#(
    parameter int                        N     = 1,
    parameter logic [ADDR_W-1:0]         REG_LO = STD_LO,
    parameter logic [ADDR_W-1:0]         REG_HI = STD_HI,
    parameter bit                        EXT   = 1'b0,
    parameter int                        PW    = STD_PW,
    parameter logic [N-1:0][ADDR_W-1:0]  OFFS  = '0,
    parameter logic [N-1:0][ADDR_W-1:0]  LENS  = '1,
    parameter logic [N-1:0][15:0]        IDS   = '0,
    parameter logic [N-1:0][3:0]         VERS  = '0
) (
    input  logic                      en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N-1:0][DATA_W-1:0]  word_in,
    output logic [N-1:0]              hit,
    output logic [ADDR_W-1:0]         idx,
    output logic [DATA_W-1:0]         rdata,
    output logic [PW-1:0]             head
);

    // resolve automatic offsets: explicit slots first, then zero-offset slots in index order
    function automatic logic [N-1:0][ADDR_W-1:0] place_slots();
        logic [N-1:0][ADDR_W-1:0] p;
        logic [N-1:0]             done;
        int                       cand;
        p    = OFFS;
        done = '0;
        for (int i = 0; i < N; i++) done[i] = (OFFS[i] != '0);
        for (int i = 0; i < N; i++) begin
            if (!done[i]) begin
                cand = int'(REG_LO);
                for (int pass = 0; pass <= N; pass++) begin
                    for (int j = 0; j < N; j++) begin
                        if (done[j] &&
                            cand <= int'(p[j]) + int'(LENS[j]) - 1 &&
                            int'(p[j]) <= cand + int'(LENS[i]) - 1)
                            cand = int'(p[j]) + int'(LENS[j]);
                    end
                end
                p[i]    = ADDR_W'(cand);
                done[i] = 1'b1;
            end
        end
        return p;
    endfunction

    localparam logic [N-1:0][ADDR_W-1:0] POS = place_slots();

    function automatic logic [N-1:0][PW-1:0] link_slots();
        logic [N-1:0][PW-1:0] nx;
        int                   best;
        for (int i = 0; i < N; i++) begin
            best = 0;
            for (int j = 0; j < N; j++) begin
                if (POS[j] > POS[i] && (best == 0 || int'(POS[j]) < best))
                    best = int'(POS[j]);
            end
            nx[i] = PW'(best * 4);
        end
        return nx;
    endfunction

    function automatic logic [PW-1:0] lowest_ptr();
        int best;
        best = int'(POS[0]);
        for (int i = 1; i < N; i++)
            if (int'(POS[i]) < best) best = int'(POS[i]);
        return PW'(best * 4);
    endfunction

    function automatic bit layout_bad();
        bit bad;
        bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (LENS[i] == '0) bad = 1'b1;
            if (POS[i] < REG_LO) bad = 1'b1;
            if (int'(POS[i]) + int'(LENS[i]) - 1 > int'(REG_HI)) bad = 1'b1;
            for (int j = i + 1; j < N; j++) begin
                if (int'(POS[i]) <= int'(POS[j]) + int'(LENS[j]) - 1 &&
                    int'(POS[j]) <= int'(POS[i]) + int'(LENS[i]) - 1)
                    bad = 1'b1;
            end
        end
        return bad;
    endfunction

    localparam logic [N-1:0][PW-1:0] NXT = link_slots();

    if (layout_bad()) begin : g_layout_err
        $error("cap_region: slot layout overlaps or leaves its window");
    end

    assign head = lowest_ptr();

    for (genvar k = 0; k < N; k++) begin : g_hit
        assign hit[k] = en &&
                        ({1'b0, addr} >= {1'b0, POS[k]}) &&
                        ({1'b0, addr} <  ({1'b0, POS[k]} + {1'b0, LENS[k]}));
    end

    function automatic logic [DATA_W-1:0] header_word(int k, logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        if (EXT) begin
            r = {12'(NXT[k]), VERS[k], IDS[k]};
        end else begin
            r = {w[31:16], 8'(NXT[k]), IDS[k][7:0]};
        end
        return r;
    endfunction

    always_comb begin
        idx   = '0;
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            if (hit[k]) begin
                idx = idx | (addr - POS[k]);
                if (addr == POS[k]) rdata = rdata | header_word(k, word_in[k]);
                else                rdata = rdata | word_in[k];
            end
        end
    end

endmodule

// File: rtl/cap_chain_decoder.sv
module cap_chain_decoder
    import cap_chain_pkg::*;
#(
    parameter int                            N_STD    = 2,
    parameter int                            N_EXT    = 1,
    parameter logic [N_STD-1:0][ADDR_W-1:0]  STD_OFFS = '0,
    parameter logic [N_STD-1:0][ADDR_W-1:0]  STD_LENS = {10'd4, 10'd2},
    parameter logic [N_STD-1:0][15:0]        STD_IDS  = {16'h0010, 16'h0001},
    parameter logic [N_EXT-1:0][ADDR_W-1:0]  EXT_OFFS = '0,
    parameter logic [N_EXT-1:0][ADDR_W-1:0]  EXT_LENS = {10'd3},
    parameter logic [N_EXT-1:0][15:0]        EXT_IDS  = {16'h0001},
    parameter logic [N_EXT-1:0][3:0]         EXT_VERS = {4'd1},
    localparam int                           NSLOT    = N_STD + N_EXT
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [MASK_W-1:0]             req_mask,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [NSLOT-1:0]              slot_sel,
    output logic                          slot_rd,
    output logic                          slot_wr,
    output logic [ADDR_W-1:0]             slot_idx,
    output logic [DATA_W-1:0]             slot_wdata,
    output logic [MASK_W-1:0]             slot_mask,
    input  logic [NSLOT-1:0][DATA_W-1:0]  slot_rdata,
    output logic [STD_PW-1:0]             cap_head_ptr,
    output logic [EXT_PW-1:0]             ext_head_ptr
);

    logic [N_STD-1:0]  std_hit;
    logic [N_EXT-1:0]  ext_hit;
    logic [ADDR_W-1:0] std_idx, ext_idx;
    logic [DATA_W-1:0] std_word, ext_word;
    logic              any_hit;

    cap_region #(
        .N(N_STD), .REG_LO(STD_LO), .REG_HI(STD_HI), .EXT(1'b0), .PW(STD_PW),
        .OFFS(STD_OFFS), .LENS(STD_LENS), .IDS(STD_IDS), .VERS('0)
    ) u_std (
        .en(req_valid), .addr(req_addr), .word_in(slot_rdata[N_STD-1:0]),
        .hit(std_hit), .idx(std_idx), .rdata(std_word), .head(cap_head_ptr)
    );

    cap_region #(
        .N(N_EXT), .REG_LO(EXT_LO), .REG_HI(EXT_HI), .EXT(1'b1), .PW(EXT_PW),
        .OFFS(EXT_OFFS), .LENS(EXT_LENS), .IDS(EXT_IDS), .VERS(EXT_VERS)
    ) u_ext (
        .en(req_valid), .addr(req_addr), .word_in(slot_rdata[NSLOT-1:N_STD]),
        .hit(ext_hit), .idx(ext_idx), .rdata(ext_word), .head(ext_head_ptr)
    );

    assign slot_sel   = {ext_hit, std_hit};
    assign any_hit    = |slot_sel;
    assign slot_idx   = std_idx | ext_idx;
    assign slot_rd    = req_valid && !req_write && any_hit;
    assign slot_wr    = req_valid &&  req_write && any_hit;
    assign slot_wdata = req_wdata;
    assign slot_mask  = req_mask;

    rsp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = req_valid && !req_write;
        st_d.data = st_d.vld ? (std_word | ext_word) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_rdata = st_q.data;

endmodule

// File: rtl/cap_chain_checker.sv
module cap_chain_checker
    import cap_chain_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [MASK_W-1:0]   req_mask,
    input logic                rsp_valid,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic [NSLOT-1:0]    slot_sel,
    input logic                slot_rd,
    input logic                slot_wr,
    input logic [DATA_W-1:0]   slot_wdata,
    input logic [MASK_W-1:0]   slot_mask
);

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel)); // R2

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R11

    AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R11

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && slot_sel == '0) |=> (rsp_rdata == '0)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || slot_sel == '0) |-> (!slot_wr && !slot_rd)); // R8

    AST_WR_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wr |-> (slot_wdata == req_wdata && slot_mask == req_mask)); // R10

endmodule

bind cap_chain_decoder cap_chain_checker #(.NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .slot_sel(slot_sel), .slot_rd(slot_rd),
    .slot_wr(slot_wr), .slot_wdata(slot_wdata), .slot_mask(slot_mask)
);

// File: tb/cap_chain_decoder_tb.sv
module cap_chain_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [NS-1:0] slot_sel;
    logic        slot_rd, slot_wr;
    logic [9:0]  slot_idx;
    logic [31:0] slot_wdata;
    logic [3:0]  slot_mask;
    logic [NS-1:0][31:0] slot_rdata;
    logic [7:0]  cap_head_ptr;
    logic [11:0] ext_head_ptr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // slots 0..2 standard, 3..4 extended
    cap_chain_decoder #(
        .N_STD(3), .N_EXT(2),
        .STD_OFFS({10'h000, 10'h000, 10'h020}),
        .STD_LENS({10'd3, 10'd6, 10'd2}),
        .STD_IDS ({16'h0010, 16'h0005, 16'h0001}),
        .EXT_OFFS({10'h100, 10'h000}),
        .EXT_LENS({10'd3, 10'd4}),
        .EXT_IDS ({16'h000B, 16'h0001}),
        .EXT_VERS({4'd2, 4'd1})
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slot_sel(slot_sel),
        .slot_rd(slot_rd), .slot_wr(slot_wr), .slot_idx(slot_idx),
        .slot_wdata(slot_wdata), .slot_mask(slot_mask), .slot_rdata(slot_rdata),
        .cap_head_ptr(cap_head_ptr), .ext_head_ptr(ext_head_ptr)
    );

    // slot storage model
    logic [31:0] mem [NS][8];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++)
                for (int i = 0; i < 8; i++)
                    mem[s][i] <= {4'hA, 4'(s), 8'(i), 16'h1234};
        end else if (slot_wr) begin
            for (int s = 0; s < NS; s++)
                if (slot_sel[s])
                    for (int b = 0; b < 4; b++)
                        if (slot_mask[b]) mem[s][slot_idx[2:0]][8*b +: 8] <= slot_wdata[8*b +: 8];
        end
    end

    always_comb begin
        for (int s = 0; s < NS; s++) slot_rdata[s] = mem[s][slot_idx[2:0]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [9:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  mask;
        logic [4:0]  sel;
        logic [9:0]  idx;
        logic [31:0] rdata;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h010, 32'h0, 4'h0, 5'b00010, 10'd0, 32'hA1005805}, // R3 R5 R9 auto slot at start
        '{1'b0, 10'h016, 32'h0, 4'h0, 5'b00100, 10'd0, 32'hA2008010}, // R3 R9 bumped slot
        '{1'b0, 10'h020, 32'h0, 4'h0, 5'b00001, 10'd0, 32'hA0000001}, // R5 last std link zero
        '{1'b0, 10'h021, 32'h0, 4'h0, 5'b00001, 10'd1, 32'hA0011234}, // R11 plain word
        '{1'b0, 10'h022, 32'h0, 4'h0, 5'b00000, 10'd0, 32'h00000000}, // R7 past slot end
        '{1'b0, 10'h015, 32'h0, 4'h0, 5'b00010, 10'd5, 32'hA1051234}, // R2 last dword
        '{1'b0, 10'h040, 32'h0, 4'h0, 5'b01000, 10'd0, 32'h40010001}, // R4 R1 ext start
        '{1'b0, 10'h043, 32'h0, 4'h0, 5'b01000, 10'd3, 32'hA3031234}, // R2
        '{1'b0, 10'h044, 32'h0, 4'h0, 5'b00000, 10'd0, 32'h00000000}, // R7
        '{1'b0, 10'h100, 32'h0, 4'h0, 5'b10000, 10'd0, 32'h0002000B}, // R4 R5 last ext link
        '{1'b0, 10'h102, 32'h0, 4'h0, 5'b10000, 10'd2, 32'hA4021234}, // R2
        '{1'b0, 10'h103, 32'h0, 4'h0, 5'b00000, 10'd0, 32'h00000000}, // R7
        '{1'b0, 10'h00F, 32'h0, 4'h0, 5'b00000, 10'd0, 32'h00000000}, // R1 below std
        '{1'b1, 10'h017, 32'hDEADBEEF, 4'h5, 5'b00100, 10'd1, 32'h0}, // R10 masked write
        '{1'b0, 10'h017, 32'h0, 4'h0, 5'b00100, 10'd1, 32'hA2AD12EF}, // R10 readback
        '{1'b1, 10'h030, 32'h12345678, 4'hF, 5'b00000, 10'd0, 32'h0}, // R8 miss write
        '{1'b1, 10'h010, 32'hFFFFFFFF, 4'hF, 5'b00010, 10'd0, 32'h0}, // R10 header write
        '{1'b0, 10'h010, 32'h0, 4'h0, 5'b00010, 10'd0, 32'hFFFF5805}, // R3 splice keeps link
        '{1'b0, 10'h3FF, 32'h0, 4'h0, 5'b00000, 10'd0, 32'h00000000}  // R7 top of ext
    };

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        check("R12 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        check("R12 rsp_rdata in reset", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        // R6 head pointers
        check("R6 std head", 32'(cap_head_ptr), 32'h40);
        check("R6 ext head", 32'(ext_head_ptr), 32'h100);

        for (int v = 0; v < NV; v++) begin
            req_valid = 1'b1;
            req_write = VECS[v].wr;
            req_addr  = VECS[v].addr;
            req_wdata = VECS[v].wdata;
            req_mask  = VECS[v].mask;
            #1;
            check($sformatf("R2 sel v%0d", v), 32'(slot_sel), 32'(VECS[v].sel));
            check($sformatf("R2 idx v%0d", v), 32'(slot_idx), 32'(VECS[v].idx));
            check($sformatf("R8 wr strobe v%0d", v), 32'(slot_wr),
                  32'(VECS[v].wr && VECS[v].sel != '0));
            check($sformatf("R8 rd strobe v%0d", v), 32'(slot_rd),
                  32'(!VECS[v].wr && VECS[v].sel != '0));
            if (VECS[v].wr && VECS[v].sel != '0) begin
                check($sformatf("R10 wdata v%0d", v), slot_wdata, VECS[v].wdata);
                check($sformatf("R10 mask v%0d", v), 32'(slot_mask), 32'(VECS[v].mask));
            end
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R11 rsp_valid v%0d", v), 32'(rsp_valid), 32'(!VECS[v].wr));
            if (!VECS[v].wr)
                check($sformatf("R3/R4/R7 rdata v%0d", v), rsp_rdata, VECS[v].rdata);
        end

        // R11 idle cycle produces no response
        @(negedge clk);
        check("R11 idle no rsp", 32'(rsp_valid), 32'd0);

        // R12 reset mid-stream clears a pending response
        req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h040;
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 reset clears rsp_valid", 32'(rsp_valid), 32'd0);
        check("R12 reset clears rsp_rdata", rsp_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule